// File: doc/BRIEF.md
# Programmable Chip-Select Timing Controller

This block drives eight chip-select lines for an external memory bus. Each channel owns two 32-bit registers. The first is a page register that holds an upper-address tag and an enable bit. The second is a timing register that holds a compare mask, setup and hold switches, a wait-state count and an optional read/write direction filter. On every bus cycle the block compares the upper address, above the 4 KB page offset, with each enabled channel. The lowest-numbered matching channel wins. The block then sequences its select, the write strobe, the read output enable and an internal transfer acknowledge.

A bus master pulses `cyc_start` for one clock with the address and direction valid. The block captures the winning channel's timing at that edge and runs the cycle on its own. A later register write does not change a cycle that is already running. After the terminating clock it can add one hold cycle. On a write, that cycle keeps address and data driven after the select drops. On a read, it keeps the select and output enable on for one more clock.

Top module: `cs_timing_ctrl`

## Requirements
- R1: After synchronous reset every output is low. Channel 0 page register reads 0x0000_0001 (tag 0, enabled). Channel 0 timing register reads 0xFFFF_F07C (all 20 mask bits set, wait count 31). Every other channel's registers read 0.
- R2: The page register of channel n is at byte offset 8n and its timing register is at 8n+4. Page layout: tag in bits 31:12, enable in bit 0. Timing layout: mask in bits 31:12, setup in bit 11, write hold in bit 10, read hold in bit 9, wait count in bits 6:2, read-only filter value in bit 1, filter enable in bit 0. All other bits read as 0.
- R3: A channel matches when it is enabled and every address bit 31:12 whose mask bit is 1 equals the tag bit. Address bits with mask 0 are ignored. When the filter is enabled, the channel matches only reads if bit 1 is 1, and only writes if bit 1 is 0.
- R4: When several channels match, the lowest-numbered one is selected. At most one select is ever high.
- R5: With setup off, the select is high from the cycle right after the edge that samples `cyc_start`. With setup on, it rises one clock later, and `busy` is high in the cycle between.
- R6: On reads, `rd_oe` is high with the select. On writes, `wr_strobe` rises with the select when setup is off, and one clock after the select when setup is on.
- R7: Count the select's cycles from 0. `xfer_ack` is high for exactly one cycle, at index max(W, S), where W is the wait count and S is 1 for a write with setup and 0 otherwise. The select drops after that cycle unless read hold applies.
- R8: With write hold on, a write adds one cycle where `drive_hold` is high and the select and strobe are low. With write hold off, the block is idle in the next cycle.
- R9: With read hold on, a read keeps the select and `rd_oe` high for one extra cycle after the acknowledge cycle, with `xfer_ack` low.
- R10: A `cyc_start` that matches no channel, or that arrives while `busy` is high, has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 6 | Register byte offset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cyc_start | input | 1 | One-clock pulse: address and direction valid |
| cyc_addr | input | 32 | Bus address |
| cyc_write | input | 1 | 1 = write cycle, 0 = read cycle |
| cs_sel | output | 8 | Per-channel chip select, active high |
| wr_strobe | output | 1 | Write strobe |
| rd_oe | output | 1 | Read output enable |
| xfer_ack | output | 1 | Internal transfer acknowledge |
| drive_hold | output | 1 | Extra write hold cycle for address, data and attributes |
| busy | output | 1 | A bus cycle is in progress |

## Verification
Every bus-cycle output is registered state plus combinational decode. The first result therefore appears in the cycle after the edge that samples `cyc_start`, or one cycle later when setup is on. The acknowledge comes max(W, S) cycles after the select rises, and any hold cycle comes right after it. For each cycle the driver builds this per-clock timeline from the requirements and queues one expected item per clock. The monitor compares one item per clock, 2 ns after each rising edge, so it never samples at an edge. Register readback is combinational and is sampled 1 ns after the offset is applied.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int NCH      = 8;
    localparam int AW       = 32;
    localparam int PAGE_LSB = 12;
    localparam int TAG_W    = AW - PAGE_LSB;
    localparam int WS_W     = 5;
    localparam int CH_W     = $clog2(NCH);
    localparam int RA_W     = CH_W + 3;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic             en;
    } page_t;

    typedef struct packed {
        logic [TAG_W-1:0] mask;
        logic             setup;
        logic             wr_hold;
        logic             rd_hold;
        logic [WS_W-1:0]  waits;
        logic             only_read;
        logic             dir_filter;
    } timing_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_ACTIVE,
        SQ_HOLD
    } seq_state_t;

    function automatic logic [31:0] page_to_word(page_t p);
        return {p.tag, 11'd0, p.en};
    endfunction

    function automatic logic [31:0] timing_to_word(timing_t t);
        return {t.mask, t.setup, t.wr_hold, t.rd_hold, 2'b00, t.waits, t.only_read, t.dir_filter};
    endfunction

    function automatic page_t word_to_page(logic [31:0] w);
        page_t p;
        p.tag = w[31:PAGE_LSB];
        p.en  = w[0];
        return p;
    endfunction

    function automatic timing_t word_to_timing(logic [31:0] w);
        timing_t t;
        t.mask       = w[31:PAGE_LSB];
        t.setup      = w[11];
        t.wr_hold    = w[10];
        t.rd_hold    = w[9];
        t.waits      = w[6:2];
        t.only_read  = w[1];
        t.dir_filter = w[0];
        return t;
    endfunction

    function automatic logic [NCH-1:0] ch_onehot(logic [CH_W-1:0] c);
        logic [NCH-1:0] v;
        v    = '0;
        v[c] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/cs_regbank.sv
module cs_regbank
    import cs_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [RA_W-1:0]           reg_addr,
    input  logic                      reg_we,
    input  logic [31:0]               reg_wdata,
    output logic [31:0]               reg_rdata,
    output page_t   [NCH-1:0]         pages,
    output timing_t [NCH-1:0]         timings
);

    localparam page_t   BOOT_PAGE   = '{tag: '0, en: 1'b1};
    localparam timing_t BOOT_TIMING = '{mask: '1, setup: 1'b0, wr_hold: 1'b0, rd_hold: 1'b0,
                                        waits: '1, only_read: 1'b0, dir_filter: 1'b0};

    logic [CH_W-1:0] ch_idx;
    logic            unused_bits;

    assign ch_idx      = reg_addr[RA_W-1:3];
    assign unused_bits = ^{reg_addr[1:0], reg_wdata[8:7]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                pages[c]   <= (c == 0) ? BOOT_PAGE   : '0;
                timings[c] <= (c == 0) ? BOOT_TIMING : '0;
            end
        end else if (reg_we) begin
            if (reg_addr[2]) timings[ch_idx] <= word_to_timing(reg_wdata);
            else             pages[ch_idx]   <= word_to_page(reg_wdata);
        end
    end

    always_comb begin
        if (reg_addr[2]) reg_rdata = timing_to_word(timings[ch_idx]);
        else             reg_rdata = page_to_word(pages[ch_idx]);
    end

endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import cs_pkg::*;
(
    input  page_t   [NCH-1:0] pages,
    input  timing_t [NCH-1:0] timings,
    input  logic [TAG_W-1:0]  tag,
    input  logic              is_write,
    output logic              hit,
    output logic [CH_W-1:0]   win
);

    logic [NCH-1:0] match;

    for (genvar c = 0; c < NCH; c++) begin : g_match
        logic addr_ok;
        logic dir_ok;
        assign addr_ok  = ((tag ^ pages[c].tag) & timings[c].mask) == '0;
        assign dir_ok   = !timings[c].dir_filter || (timings[c].only_read != is_write);
        assign match[c] = pages[c].en && addr_ok && dir_ok;
    end

    // Fixed priority: the lowest index overrides, so scan from the top down.
    always_comb begin
        hit = |match;
        win = '0;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (match[c]) win = CH_W'(c);
        end
    end

endmodule

// File: rtl/cs_sequencer.sv
module cs_sequencer
    import cs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            hit,
    input  logic [CH_W-1:0] win,
    input  timing_t         win_timing,
    input  logic            is_write,
    output logic [NCH-1:0]  sel,
    output logic            wr_strobe,
    output logic            rd_oe,
    output logic            ack,
    output logic            drive_hold,
    output logic            busy
);

    seq_state_t      state;
    logic [CH_W-1:0] cur_ch;
    timing_t         cur_t;
    logic            cur_wr;
    logic [WS_W-1:0] cnt;
    logic            aged;

    logic in_active;
    logic in_hold;
    logic strobe_ok;

    assign in_active = (state == SQ_ACTIVE);
    assign in_hold   = (state == SQ_HOLD);
    // With setup on, a write must first spend one select cycle without its strobe.
    assign strobe_ok = !cur_t.setup || aged;

    assign busy       = (state != SQ_IDLE);
    assign wr_strobe  = in_active && cur_wr && strobe_ok;
    assign rd_oe      = !cur_wr && (in_active || in_hold);
    assign ack        = in_active && (cnt == '0) && (!cur_wr || strobe_ok);
    assign drive_hold = in_hold && cur_wr;
    assign sel        = (in_active || (in_hold && !cur_wr)) ? ch_onehot(cur_ch) : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            cur_ch <= '0;
            cur_t  <= '0;
            cur_wr <= 1'b0;
            cnt    <= '0;
            aged   <= 1'b0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (start && hit) begin
                        cur_ch <= win;
                        cur_t  <= win_timing;
                        cur_wr <= is_write;
                        cnt    <= win_timing.waits;
                        aged   <= 1'b0;
                        state  <= win_timing.setup ? SQ_SETUP : SQ_ACTIVE;
                    end
                end
                SQ_SETUP: state <= SQ_ACTIVE;
                SQ_ACTIVE: begin
                    aged <= 1'b1;
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    if (ack) begin
                        if (cur_wr ? cur_t.wr_hold : cur_t.rd_hold) state <= SQ_HOLD;
                        else                                         state <= SQ_IDLE;
                    end
                end
                SQ_HOLD: state <= SQ_IDLE;
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cs_timing_ctrl.sv
module cs_timing_ctrl
    import cs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic             reg_we,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             cyc_start,
    input  logic [AW-1:0]    cyc_addr,
    input  logic             cyc_write,
    output logic [NCH-1:0]   cs_sel,
    output logic             wr_strobe,
    output logic             rd_oe,
    output logic             xfer_ack,
    output logic             drive_hold,
    output logic             busy
);

    page_t   [NCH-1:0] pages;
    timing_t [NCH-1:0] timings;
    logic              hit;
    logic [CH_W-1:0]   win;
    logic              unused_offset;

    assign unused_offset = ^cyc_addr[PAGE_LSB-1:0];

    cs_regbank u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pages     (pages),
        .timings   (timings)
    );

    cs_decode u_dec (
        .pages    (pages),
        .timings  (timings),
        .tag      (cyc_addr[AW-1:PAGE_LSB]),
        .is_write (cyc_write),
        .hit      (hit),
        .win      (win)
    );

    cs_sequencer u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (cyc_start),
        .hit        (hit),
        .win        (win),
        .win_timing (timings[win]),
        .is_write   (cyc_write),
        .sel        (cs_sel),
        .wr_strobe  (wr_strobe),
        .rd_oe      (rd_oe),
        .ack        (xfer_ack),
        .drive_hold (drive_hold),
        .busy       (busy)
    );

endmodule

// File: rtl/cs_timing_checks.sv
module cs_timing_checks
    import cs_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic [NCH-1:0] cs_sel,
    input logic           wr_strobe,
    input logic           rd_oe,
    input logic           xfer_ack,
    input logic           drive_hold,
    input logic           busy
);

    assert_sel_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cs_sel));

    assert_no_strobe_and_oe_R6: assert property (@(posedge clk) disable iff (rst)
        !(wr_strobe && rd_oe));

    assert_strobe_needs_sel_R6: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> (cs_sel != '0));

    assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |=> !xfer_ack);

    assert_ack_needs_sel_R7: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |-> (cs_sel != '0) && busy);

    assert_hold_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        drive_hold |-> $past(wr_strobe) && (cs_sel == '0) && !wr_strobe);

    assert_oe_within_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        rd_oe |-> busy && (cs_sel != '0));

endmodule

bind cs_timing_ctrl cs_timing_checks u_checks (
    .clk        (clk),
    .rst        (rst),
    .cs_sel     (cs_sel),
    .wr_strobe  (wr_strobe),
    .rd_oe      (rd_oe),
    .xfer_ack   (xfer_ack),
    .drive_hold (drive_hold),
    .busy       (busy)
);

// File: tb/cs_timing_ctrl_tb.sv
module cs_timing_ctrl_tb;

    typedef struct {
        logic [7:0] sel;
        logic       wr;
        logic       oe;
        logic       ack;
        logic       dh;
        logic       bsy;
        string      rq;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cyc_start = 1'b0;
    logic [31:0] cyc_addr = '0;
    logic        cyc_write = 1'b0;
    logic [7:0]  cs_sel;
    logic        wr_strobe, rd_oe, xfer_ack, drive_hold, busy;

    int   checks = 0;
    int   errors = 0;
    bit   done = 0;
    exp_t q[$];

    always #4 clk = ~clk;

    cs_timing_ctrl u_dut (
        .clk        (clk),
        .rst        (rst),
        .reg_addr   (reg_addr),
        .reg_we     (reg_we),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cyc_start  (cyc_start),
        .cyc_addr   (cyc_addr),
        .cyc_write  (cyc_write),
        .cs_sel     (cs_sel),
        .wr_strobe  (wr_strobe),
        .rd_oe      (rd_oe),
        .xfer_ack   (xfer_ack),
        .drive_hold (drive_hold),
        .busy       (busy)
    );

    function automatic logic [31:0] timing_word(logic [19:0] m, logic su, logic wh, logic rh,
                                                int ws, logic rdonly, logic filt);
        return {m, su, wh, rh, 2'b00, 5'(ws), rdonly, filt};
    endfunction

    function automatic void push(logic [7:0] s, logic w, logic o, logic a, logic d, logic b, string rq);
        exp_t e;
        e.sel = s; e.wr = w; e.oe = o; e.ack = a; e.dh = d; e.bsy = b; e.rq = rq;
        q.push_back(e);
    endfunction

    // Monitor: one expected item per clock, sampled 2 ns after the rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if ({cs_sel, wr_strobe, rd_oe, xfer_ack, drive_hold, busy} !==
                    {e.sel, e.wr, e.oe, e.ack, e.dh, e.bsy}) begin
                    errors++;
                    $display("FAIL %s: sel/wr/oe/ack/hold/busy actual %h/%b/%b/%b/%b/%b expected %h/%b/%b/%b/%b/%b",
                             e.rq, cs_sel, wr_strobe, rd_oe, xfer_ack, drive_hold, busy,
                             e.sel, e.wr, e.oe, e.ack, e.dh, e.bsy);
                end
            end
        end
    end

    task automatic reg_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_check(input logic [5:0] a, input logic [31:0] exp, input string rq);
        @(negedge clk);
        reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: reg offset %0d actual %h expected %h", rq, a, reg_rdata, exp);
        end
    endtask

    // Driver: issue one bus cycle and queue its expected per-clock timeline.
    // ch < 0 means no channel is expected to answer.
    task automatic bus_cycle(input logic [31:0] a, input logic w, input int ch,
                             input logic su, input logic wh, input logic rh, input int ws,
                             input string rq, input bit poke);
        int         n;
        logic [7:0] oh;
        @(negedge clk);
        cyc_addr = a; cyc_write = w; cyc_start = 1'b1;
        if (ch < 0) begin
            push('0, 0, 0, 0, 0, 0, rq);
        end else begin
            oh = 8'(1 << ch);
            if (su) push('0, 0, 0, 0, 0, 1, rq);
            n = ((su && w) && ws < 1) ? 1 : ws;
            for (int k = 0; k <= n; k++)
                push(oh, w && (!su || k >= 1), !w, k == n, 0, 1, rq);
            if (w && wh)  push('0, 0, 0, 0, 1, 1, rq);
            if (!w && rh) push(oh, 0, 1, 0, 0, 1, rq);
        end
        push('0, 0, 0, 0, 0, 0, rq);
        @(negedge clk);
        cyc_start = 1'b0;
        if (poke) begin
            cyc_addr = 32'h0000_0040; cyc_write = 1'b0; cyc_start = 1'b1;
            @(negedge clk);
            cyc_start = 1'b0;
        end
        wait (q.size() == 0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run still active, actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        checks++;
        if ({cs_sel, wr_strobe, rd_oe, xfer_ack, drive_hold, busy} !== '0) begin
            errors++;
            $display("FAIL R1: outputs after reset actual %h expected 0",
                     {cs_sel, wr_strobe, rd_oe, xfer_ack, drive_hold, busy});
        end
        reg_check(6'd0,  32'h0000_0001, "R1");
        reg_check(6'd4,  32'hFFFF_F07C, "R1");
        reg_check(6'd28, 32'h0000_0000, "R1");
        reg_check(6'd56, 32'h0000_0000, "R1");

        // R1 + R7: boot channel with 31 wait states
        bus_cycle(32'h0000_0100, 1'b0, 0, 0, 0, 0, 31, "R1", 0);

        // R2: layout and reserved bits
        reg_write(6'd60, 32'hFFFF_FFFF);
        reg_check(6'd60, 32'hFFFF_FE7F, "R2");
        reg_write(6'd56, 32'hFFFF_FFFF);
        reg_check(6'd56, 32'hFFFF_F001, "R2");
        reg_write(6'd56, 32'h0);
        reg_write(6'd60, 32'h0);
        reg_check(6'd56, 32'h0, "R2");

        // channel setup
        reg_write(6'd4,  timing_word(20'hFFFFF, 0, 0, 0, 0, 0, 0));
        reg_write(6'd8,  32'h1000_0001);
        reg_write(6'd12, timing_word(20'hFFFF0, 0, 0, 0, 2, 0, 0));
        reg_write(6'd16, 32'h1000_5001);
        reg_write(6'd20, timing_word(20'hFFFFF, 1, 1, 0, 1, 0, 0));
        reg_write(6'd24, 32'h2000_0001);
        reg_write(6'd28, timing_word(20'hFFFFF, 1, 1, 0, 0, 0, 0));
        reg_write(6'd32, 32'h3000_0001);
        reg_write(6'd36, timing_word(20'hFFFFF, 0, 0, 1, 1, 1, 1));
        reg_write(6'd40, 32'h4000_0001);
        reg_write(6'd44, timing_word(20'hFFFFF, 0, 0, 0, 0, 0, 0));
        reg_check(6'd36, 32'hFFFF_F207, "R2");

        // R3: masked-off tag bits ignored
        bus_cycle(32'h1000_F123, 1'b0, 1, 0, 0, 0, 2, "R3", 0);
        // R4: channel 1 and channel 2 both match, channel 1 wins
        bus_cycle(32'h1000_5000, 1'b1, 1, 0, 0, 0, 2, "R4", 0);
        // R5 / R6 / R8: setup write with write hold
        bus_cycle(32'h2000_0ABC, 1'b1, 3, 1, 1, 0, 0, "R8", 0);
        // R5: setup read, hold not applied to reads
        bus_cycle(32'h2000_0ABC, 1'b0, 3, 1, 1, 0, 0, "R5", 0);
        // R9: read hold on a read-only channel
        bus_cycle(32'h3000_0010, 1'b0, 4, 0, 0, 1, 1, "R9", 0);
        // R3: direction filter rejects a write
        bus_cycle(32'h3000_0010, 1'b1, -1, 0, 0, 0, 0, "R3", 0);
        // R8: write without hold returns to idle at once
        bus_cycle(32'h4000_0000, 1'b1, 5, 0, 0, 0, 0, "R8", 0);
        // R10: no channel matches
        bus_cycle(32'h9000_0000, 1'b0, -1, 0, 0, 0, 0, "R10", 0);
        // R10: start while busy ignored
        bus_cycle(32'h1000_5000, 1'b0, 1, 0, 0, 0, 2, "R10", 1);
        // R4: with channel 1 disabled, channel 2 takes the overlap
        reg_write(6'd8, 32'h1000_0000);
        bus_cycle(32'h1000_5000, 1'b1, 2, 1, 1, 0, 1, "R4", 0);
        // R7: setup write, wait count above the minimum
        reg_write(6'd20, timing_word(20'hFFFFF, 1, 0, 0, 3, 0, 0));
        bus_cycle(32'h1000_5000, 1'b1, 2, 1, 0, 0, 3, "R7", 0);

        finish_run();
    end

endmodule